// File: doc/BRIEF.md
# Product-Term Cluster Allocator

This block sits between the AND-term array of one logic block and its macrocells. The AND terms are taken four at a time as clusters. Each cluster ORs its four terms and is steered, whole, to exactly one macrocell inside a small window of neighbouring cells. Each macrocell ORs together every cluster steered to it, and that OR forms its sum-of-products input. Cluster c is fed by terms 4c to 4c+3.

Each cluster has a three-bit steering field. The field holds an enable and a two-bit signed offset, and the cluster's target cell is its own index plus that offset. The reachable window is fixed and does not wrap at the ends of the block, so cells near either end have fewer clusters to draw on. Two window variants are selected by a parameter:
- The single-cell variant lets cell n draw on clusters n-1 to n+1.
- The paired variant is used when output and buried cells alternate. It lets cell n draw on clusters n-1 to n+2.

Any enabled cluster whose offset leaves the window, or points past either end, is reported per cluster and through a summary flag, and is dropped from every sum. The block is purely combinational.

Top module: `pt_cluster_alloc`

## Requirements
- R1: Cluster c is the OR of product terms 4c, 4c+1, 4c+2 and 4c+3, and any one of those terms alone carries the cluster into its target cell's sum.
- R2: A cell's sum is the OR of all clusters legally steered to it, and several clusters may share one cell.
- R3: A cell that receives no clusters drives a sum of 0, whatever the product terms are.
- R4: The steering field of cluster c is steer_i bits [3c+2:3c]. Bit 3c+2 is the enable, and bits 3c+1:3c hold a two's-complement offset from -2 to +1. The target is c plus the offset. A disabled cluster reaches no cell and raises no error.
- R5: With PAIRED=0, the legal offsets are -1, 0 and +1. An enabled cluster with offset -2 (code 2'b10) is flagged.
- R6: With PAIRED=1, the offsets -2, -1, 0 and +1 are all legal, so cell n reaches clusters n-1 to n+2.
- R7: The window does not wrap. An enabled cluster whose target is below 0 or above CELLS-1 is flagged; for example, cluster 0 with offset -1, or cluster CELLS-1 with offset +1.
- R8: A flagged cluster sets its own bit in cluster_err_o and contributes to no sum. cfg_err_o is high exactly when any cluster_err_o bit is high.
- R9: The outputs follow the inputs with no clock, so a change of terms or steering shows up without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pterm_i | input | CELLS*TERMS_PER_CLUSTER | Product-term outputs of the AND array, cluster c on bits [4c+3:4c] |
| steer_i | input | CELLS*3 | Per-cluster steering: enable and signed offset |
| sum_o | output | CELLS | OR sum delivered to each macrocell |
| cluster_err_o | output | CELLS | Per-cluster illegal-steering flag |
| cfg_err_o | output | 1 | High when any cluster is illegally steered |

## Verification
The hardest case to reach is a cluster that is legal only at the far end of the paired window (offset -2). It must land two cells down while neighbouring clusters compete for the same cell. The same offset must be rejected when it would cross cell 0, and in the single-cell variant. To reach it, the bench holds every term low except those of the cluster under test, so a misrouted or leaked cluster shows up as a wrong sum bit. Directed edge cases are then followed by pseudo-random steering against an independent model, with both variants instantiated side by side.

// File: rtl/pt_alloc_pkg.sv
package pt_alloc_pkg;

    // Width of one steering field: enable plus two-bit signed offset.
    localparam int STEER_W    = 3;
    localparam int MAX_OFFSET = 1;

    typedef struct packed {
        logic              en;
        logic signed [1:0] off;
    } steer_t;

    // Most negative legal offset for the chosen window variant.
    function automatic int min_offset(input bit paired);
        return paired ? -2 : -1;
    endfunction

    // Number of distinct targets a cluster may select.
    function automatic int win_size(input bit paired);
        return MAX_OFFSET - min_offset(paired) + 1;
    endfunction

endpackage

// File: rtl/pt_cluster_or.sv
module pt_cluster_or #(
    parameter int NUM_CL = 16,
    parameter int TPC    = 4
) (
    input  logic [NUM_CL*TPC-1:0] terms_i,
    output logic [NUM_CL-1:0]     hit_o
);

    for (genvar c = 0; c < NUM_CL; c++) begin : g_cl
        assign hit_o[c] = |terms_i[c*TPC +: TPC];
    end

endmodule

// File: rtl/pt_cluster_steer.sv
module pt_cluster_steer
    import pt_alloc_pkg::*;
#(
    parameter int NUM_CL = 16,
    parameter bit PAIRED = 1'b0,
    localparam int MIN_OFF = min_offset(PAIRED),
    localparam int WIN     = win_size(PAIRED)
) (
    input  logic [NUM_CL*STEER_W-1:0]   steer_i,
    output logic [NUM_CL-1:0][WIN-1:0]  sel_o,
    output logic [NUM_CL-1:0]           err_o
);

    localparam int SLOT_W = (WIN > 1) ? $clog2(WIN) : 1;

    for (genvar c = 0; c < NUM_CL; c++) begin : g_dec
        steer_t           fld;
        int               rel;
        int               tgt;
        logic             legal;
        logic [WIN-1:0]   sel_c;

        assign fld = steer_t'(steer_i[c*STEER_W +: STEER_W]);

        always_comb begin
            rel   = int'(fld.off);
            tgt   = c + rel;
            legal = fld.en && (rel >= MIN_OFF) && (rel <= MAX_OFFSET)
                    && (tgt >= 0) && (tgt < NUM_CL);
            sel_c = '0;
            if (legal) begin
                sel_c[SLOT_W'(rel - MIN_OFF)] = 1'b1;
            end
        end

        assign sel_o[c] = sel_c;
        assign err_o[c] = fld.en && !legal;
    end

endmodule

// File: rtl/pt_cell_gather.sv
module pt_cell_gather #(
    parameter int NUM_CL  = 16,
    parameter int WIN     = 3,
    parameter int MIN_OFF = -1
) (
    input  logic [NUM_CL-1:0]          hit_i,
    input  logic [NUM_CL-1:0][WIN-1:0] sel_i,
    output logic [NUM_CL-1:0]          sum_o
);

    for (genvar n = 0; n < NUM_CL; n++) begin : g_cell
        logic [WIN-1:0] contrib;
        for (genvar s = 0; s < WIN; s++) begin : g_slot
            // Cluster whose slot s lands on cell n.
            localparam int SRC = n - MIN_OFF - s;
            if (SRC >= 0 && SRC < NUM_CL) begin : g_reach
                assign contrib[s] = hit_i[SRC] & sel_i[SRC][s];
            end else begin : g_edge
                assign contrib[s] = 1'b0;
            end
        end
        assign sum_o[n] = |contrib;
    end

endmodule

// File: rtl/pt_cluster_alloc.sv
module pt_cluster_alloc
    import pt_alloc_pkg::*;
#(
    parameter int CELLS             = 16,
    parameter int TERMS_PER_CLUSTER = 4,
    parameter bit PAIRED            = 1'b0
) (
    input  logic [CELLS*TERMS_PER_CLUSTER-1:0] pterm_i,
    input  logic [CELLS*STEER_W-1:0]           steer_i,
    output logic [CELLS-1:0]                   sum_o,
    output logic [CELLS-1:0]                   cluster_err_o,
    output logic                               cfg_err_o
);

    localparam int MIN_OFF = min_offset(PAIRED);
    localparam int WIN     = win_size(PAIRED);

    logic [CELLS-1:0]          hit;
    logic [CELLS-1:0][WIN-1:0] sel;

    pt_cluster_or #(
        .NUM_CL (CELLS),
        .TPC    (TERMS_PER_CLUSTER)
    ) u_or (
        .terms_i (pterm_i),
        .hit_o   (hit)
    );

    pt_cluster_steer #(
        .NUM_CL (CELLS),
        .PAIRED (PAIRED)
    ) u_steer (
        .steer_i (steer_i),
        .sel_o   (sel),
        .err_o   (cluster_err_o)
    );

    pt_cell_gather #(
        .NUM_CL  (CELLS),
        .WIN     (WIN),
        .MIN_OFF (MIN_OFF)
    ) u_gather (
        .hit_i (hit),
        .sel_i (sel),
        .sum_o (sum_o)
    );

    assign cfg_err_o = |cluster_err_o;

endmodule

// File: rtl/pt_cluster_alloc_chk.sv
module pt_cluster_alloc_chk
    import pt_alloc_pkg::*;
#(
    parameter int CELLS             = 16,
    parameter int TERMS_PER_CLUSTER = 4,
    parameter bit PAIRED            = 1'b0
) (
    input logic [CELLS*TERMS_PER_CLUSTER-1:0] pterm_i,
    input logic [CELLS*STEER_W-1:0]           steer_i,
    input logic [CELLS-1:0]                   sum_o,
    input logic [CELLS-1:0]                   cluster_err_o,
    input logic                               cfg_err_o
);

    logic [CELLS-1:0] en_mask;
    for (genvar c = 0; c < CELLS; c++) begin : g_en
        assign en_mask[c] = steer_i[c*STEER_W + 2];
    end

    always_comb begin
        // R3: nothing enabled means every cell is silent
        if (en_mask == '0)
            p_idle_zero_r3: assert (sum_o == '0);
        // R1: no active term means no active sum
        if (pterm_i == '0)
            p_no_terms_zero_r1: assert (sum_o == '0);
        // R4: only an enabled cluster can be flagged
        p_err_needs_en_r4: assert ((cluster_err_o & ~en_mask) == '0);
        // R8: summary flag tracks the per-cluster flags
        p_err_summary_r8: assert (cfg_err_o == (cluster_err_o != '0));
        // R8: when every enabled cluster is flagged, no cell gets anything
        if ((en_mask & ~cluster_err_o) == '0)
            p_err_silent_r8: assert (sum_o == '0);
        // R7: lowest cluster cannot step below cell 0
        if (steer_i[2:0] == 3'b111)
            p_edge_low_r7: assert (cluster_err_o[0]);
        // R7: highest cluster cannot step past the last cell
        if (steer_i[CELLS*STEER_W-1 -: STEER_W] == 3'b101)
            p_edge_high_r7: assert (cluster_err_o[CELLS-1]);
    end

    for (genvar c = 0; c < CELLS; c++) begin : g_mode
        always_comb begin
            // R5: single-cell window refuses offset -2
            if (!PAIRED && steer_i[c*STEER_W +: STEER_W] == 3'b110)
                p_single_win_r5: assert (cluster_err_o[c]);
        end
    end

endmodule

bind pt_cluster_alloc pt_cluster_alloc_chk #(
    .CELLS             (CELLS),
    .TERMS_PER_CLUSTER (TERMS_PER_CLUSTER),
    .PAIRED            (PAIRED)
) u_chk (
    .pterm_i       (pterm_i),
    .steer_i       (steer_i),
    .sum_o         (sum_o),
    .cluster_err_o (cluster_err_o),
    .cfg_err_o     (cfg_err_o)
);

// File: tb/pt_cluster_alloc_test.sv
module pt_cluster_alloc_test;

    localparam int N = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [N*4-1:0] pterm;
    logic [N*3-1:0] steer;
    logic [N-1:0]   sum_s, err_s, sum_p, err_p;
    logic           any_s, any_p;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    pt_cluster_alloc #(.CELLS(N), .TERMS_PER_CLUSTER(4), .PAIRED(1'b0)) uut (
        .pterm_i (pterm), .steer_i (steer),
        .sum_o (sum_s), .cluster_err_o (err_s), .cfg_err_o (any_s)
    );

    pt_cluster_alloc #(.CELLS(N), .TERMS_PER_CLUSTER(4), .PAIRED(1'b1)) uut_pair (
        .pterm_i (pterm), .steer_i (steer),
        .sum_o (sum_p), .cluster_err_o (err_p), .cfg_err_o (any_p)
    );

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Independent model built from R1..R8.
    task automatic model(input logic [N*4-1:0] pt, input logic [N*3-1:0] cf, input bit paired,
                         output logic [N-1:0] s, output logic [N-1:0] e);
        s = '0;
        e = '0;
        for (int c = 0; c < N; c++) begin
            logic [2:0] f;
            int off;
            int t;
            f = cf[c*3 +: 3];
            if (!f[2]) continue;
            off = (f[1:0] == 2'b00) ? 0 : (f[1:0] == 2'b01) ? 1 : (f[1:0] == 2'b10) ? -2 : -1;
            t = c + off;
            if ((!paired && off == -2) || t < 0 || t >= N) e[c] = 1'b1;
            else if (pt[c*4 +: 4] != 4'b0) s[t] = 1'b1;
        end
    endtask

    function automatic logic [N*3-1:0] one_field(input int c, input logic [2:0] f);
        logic [N*3-1:0] v;
        v = '0;
        v[c*3 +: 3] = f;
        return v;
    endfunction

    task automatic apply(input logic [N*4-1:0] pt, input logic [N*3-1:0] cf);
        @(negedge clk);
        pterm = pt;
        steer = cf;
        #1;
    endtask

    task automatic t_idle();
        apply('1, '0);
        check("R3 idle sum", sum_s, '0);
        check("R4 idle err", err_s, '0);
        check("R8 idle summary", {15'b0, any_s}, '0);
    endtask

    task automatic t_identity();
        logic [N*4-1:0] pt;
        logic [N*3-1:0] cf;
        pt = '0;
        cf = '0;
        for (int c = 0; c < N; c++) begin
            cf[c*3 +: 3] = 3'b100;
            if (c % 2 == 0) pt[c*4 + (c/2) % 4] = 1'b1;
        end
        apply(pt, cf);
        check("R2 identity steering", sum_s, 16'h5555);
        check("R2 identity steering paired", sum_p, 16'h5555);
    endtask

    task automatic t_term_positions();
        for (int k = 0; k < 4; k++) begin
            logic [N*4-1:0] pt;
            pt = '0;
            pt[5*4 + k] = 1'b1;
            apply(pt, one_field(5, 3'b101));
            check($sformatf("R1 term %0d of cluster 5", k), sum_s, 16'h0040);
        end
        apply('0, one_field(5, 3'b101));
        check("R1 no term active", sum_s, '0);
    endtask

    task automatic t_merge();
        logic [N*3-1:0] cf;
        logic [N*4-1:0] pt;
        cf = one_field(4, 3'b101) | one_field(5, 3'b100) | one_field(6, 3'b111);
        pt = '0;
        pt[6*4 + 2] = 1'b1;
        apply(pt, cf);
        check("R2 merge from upper neighbour", sum_s, 16'h0020);
        check("R3 neighbours idle", sum_s & ~16'h0020, '0);
    endtask

    task automatic t_edges();
        apply('1, one_field(0, 3'b111));
        check("R7 cluster0 below edge err", err_s, 16'h0001);
        check("R8 dropped cluster0", sum_s, '0);
        check("R8 summary low edge", {15'b0, any_s}, 16'h0001);
        apply('1, one_field(N-1, 3'b101));
        check("R7 top cluster past edge err", err_s, 16'h8000);
        check("R8 dropped top cluster", sum_s, '0);
        apply('1, one_field(0, 3'b101));
        check("R7 cluster0 up legal", sum_s, 16'h0002);
        check("R7 cluster0 up no err", err_s, '0);
    endtask

    task automatic t_single_window();
        apply('1, one_field(7, 3'b110));
        check("R5 offset -2 flagged", err_s, 16'h0080);
        check("R5 offset -2 dropped", sum_s, '0);
        apply('1, one_field(7, 3'b010));
        check("R4 disabled cluster silent", sum_s | err_s, '0);
    endtask

    task automatic t_paired();
        logic [N*4-1:0] pt;
        pt = '0;
        pt[7*4 + 3] = 1'b1;
        apply(pt, one_field(7, 3'b110) | one_field(4, 3'b101));
        check("R6 paired offset -2 lands two down", sum_p, 16'h0020);
        check("R6 paired offset -2 no err", err_p, '0);
        apply('1, one_field(1, 3'b110));
        check("R7 paired cluster1 -2 err", err_p, 16'h0002);
        check("R7 paired cluster1 -2 dropped", sum_p, '0);
        apply('1, one_field(2, 3'b110));
        check("R6 paired cluster2 to cell0", sum_p, 16'h0001);
    endtask

    task automatic t_comb();
        logic [N*4-1:0] pt;
        pt = '0;
        pt[3*4] = 1'b1;
        apply(pt, one_field(3, 3'b100));
        #1;
        pterm = '0;
        #1;
        check("R9 sum falls with no edge", sum_s, '0);
        pterm = pt;
        #1;
        check("R9 sum rises with no edge", sum_s, 16'h0008);
    endtask

    task automatic t_random();
        for (int i = 0; i < 60; i++) begin
            logic [N*4-1:0] pt;
            logic [N*3-1:0] cf;
            logic [N-1:0] es, ee;
            pt = '0;
            cf = '0;
            for (int c = 0; c < N; c++) begin
                pt[c*4 +: 4] = (($urandom % 3) == 0) ? 4'($urandom) : 4'b0;
                cf[c*3 +: 3] = 3'($urandom);
            end
            apply(pt, cf);
            model(pt, cf, 1'b0, es, ee);
            check("R2 random single sum", sum_s, es);
            check("R8 random single err", err_s, ee);
            model(pt, cf, 1'b1, es, ee);
            check("R6 random paired sum", sum_p, es);
            check("R8 random paired err", err_p, ee);
        end
    endtask

    initial begin
        pterm = '0;
        steer = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_idle();
        t_identity();
        t_term_positions();
        t_merge();
        t_edges();
        t_single_window();
        t_paired();
        t_comb();
        t_random();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule